// File: doc/BRIEF.md
# Program Memory Table Read Unit

This unit carries out table-lookup reads from the program memory of a small 8-bit controller core. When the core issues a table read, the unit builds an 11-bit program memory address. The low eight bits always come from a writable table pointer register. The top three bits come from one of two places, chosen by a variant select. The first variant takes them from the page bits of the current program counter. The second variant forces them to all ones, so that the read reaches the last page.

The unit fetches one 16-bit word. It returns the low byte, together with the destination register index, as a one-cycle write to the core's data registers. In the same clock edge it loads the high byte into a holding register. The holding register is visible to the core but cannot be written through the data write port. Every operation occupies exactly two cycles, and `busy` is raised for both of them so that the core stalls. The program counter is never touched, so the core continues fetching after the table read instruction.

The data write port selects its target with `wr_sel`. The value 0 selects the table pointer. The value 1 selects the high-byte holding register, and writes to it are discarded.

Top module: `tblrd_unit`

## Requirements
- R1: Synchronous reset clears the table pointer and the high-byte register to 0x00, and drops `busy`, `pm_re` and `dst_we` to 0.
- R2: Bits 7..0 of the fetched address equal the table pointer value held in the register at the clock edge that accepts the strobe.
- R3: With `op_last` = 0, address bits 10..8 equal `pc_page` as sampled at the accepting edge.
- R4: With `op_last` = 1, address bits 10..8 are 3'b111.
- R5: An accepted strobe raises `busy` for exactly two cycles. `pm_re` is high in the first of those cycles only, and `pm_addr` holds its value across both cycles.
- R6: In the cycle after the second busy cycle, `dst_we` pulses for one cycle. During that pulse `dst_data` carries bits 7..0 of the fetched word and `dst_addr` carries the `op_dst` value captured at acceptance.
- R7: The high-byte register takes bits 15..8 of the fetched word on the same edge that raises `dst_we`, and keeps that value until the next table read or reset.
- R8: A data write with `wr_sel` = 1 changes neither the high-byte register nor the table pointer.
- R9: A data write with `wr_sel` = 0 loads `wr_data` into the table pointer on that edge. When this write coincides with an accepted strobe, the fetch uses the old pointer value.
- R10: A strobe that arrives while `busy` is high is ignored: it starts no fetch and produces no result.
- R11: Changes to `pc_page`, `op_last`, `op_dst` or the table pointer after acceptance do not alter the address or the destination of the read already in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Table read instruction strobe |
| op_last | input | 1 | Variant select: 0 current page, 1 last page |
| op_dst | input | 7 | Destination data register index |
| pc_page | input | 3 | Program counter bits 10..8 |
| wr_en | input | 1 | Data write enable |
| wr_sel | input | 1 | Write target: 0 table pointer, 1 high-byte register (ignored) |
| wr_data | input | 8 | Data write value |
| pm_re | output | 1 | Program memory read enable |
| pm_addr | output | 11 | Program memory read address |
| pm_rdata | input | 16 | Program memory word, valid the cycle after `pm_re` |
| busy | output | 1 | Core stall while a table read is in progress |
| dst_we | output | 1 | Destination write strobe |
| dst_addr | output | 7 | Destination register index |
| dst_data | output | 8 | Low byte of the fetched word |
| hb_q | output | 8 | High-byte holding register |
| ptr_q | output | 8 | Table pointer register |

## Verification
The bench keeps the table pointer in a software model and predicts every address from that model and from the page bits it drives. This exposes a unit that samples the pointer one edge late: such a unit would pick up a pointer written in the same cycle as the strobe, or one written while the read is in flight, and read the wrong word. Strobes held through the busy window would show up as extra fetches or extra destination writes in a unit that re-arms too early. A write aimed at the high-byte register is followed by a readback of both registers, which catches a decode that lets that write through or sends it to the pointer. Back-to-back reads that alternate between the two variants catch a page mux that is stuck or inverted, and a mid-run reset checks that both registers clear.

// File: rtl/tblrd_pkg.sv
package tblrd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_CAPT  = 2'd2
  } tblrd_state_e;

  localparam logic SEL_PTR = 1'b0;
  localparam logic SEL_HB  = 1'b1;

endpackage

// File: rtl/tblrd_ptr.sv
module tblrd_ptr #(
  parameter int PTR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [PTR_W-1:0] wdata,
  output logic [PTR_W-1:0] ptr
);

  always_ff @(posedge clk) begin
    if (rst) ptr <= '0;
    else if (we) ptr <= wdata;
  end

  // R9
  ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(ptr));

  // R9
  ptr_load_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> ptr == $past(wdata));

endmodule

// File: rtl/tblrd_addr.sv
module tblrd_addr #(
  parameter int PC_W  = 11,
  parameter int PTR_W = 8,
  localparam int PAGE_W = PC_W - PTR_W
) (
  input  logic              last_page,
  input  logic [PAGE_W-1:0] pc_page,
  input  logic [PTR_W-1:0]  ptr,
  output logic [PC_W-1:0]   addr
);

  logic [PAGE_W-1:0] page_sel;

  for (genvar i = 0; i < PAGE_W; i++) begin : g_page
    assign page_sel[i] = last_page | pc_page[i];
  end

  always_comb begin
    addr = {page_sel, ptr};
  end

endmodule

// File: rtl/tblrd_hold.sv
module tblrd_hold #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else if (load) q <= din;
  end

  // R8
  hb_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(q));

  // R7
  hb_load_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> q == $past(din));

endmodule

// File: rtl/tblrd_ctrl.sv
module tblrd_ctrl
  import tblrd_pkg::*;
#(
  parameter int PC_W   = 11,
  parameter int WORD_W = 16,
  parameter int DST_AW = 7,
  localparam int BYTE_W = WORD_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [DST_AW-1:0] op_dst,
  input  logic [PC_W-1:0]   addr_in,
  input  logic [WORD_W-1:0] pm_rdata,
  output logic              pm_re,
  output logic [PC_W-1:0]   pm_addr,
  output logic              busy,
  output logic              cap_en,
  output logic [BYTE_W-1:0] hi_byte,
  output logic              dst_we,
  output logic [DST_AW-1:0] dst_addr,
  output logic [BYTE_W-1:0] dst_data
);

  tblrd_state_e state;
  logic         accept;

  assign accept  = op_valid && (state == ST_IDLE);
  assign cap_en  = (state == ST_CAPT);
  assign hi_byte = pm_rdata[WORD_W-1:BYTE_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      pm_re    <= 1'b0;
      pm_addr  <= '0;
      busy     <= 1'b0;
      dst_we   <= 1'b0;
      dst_addr <= '0;
      dst_data <= '0;
    end else begin
      dst_we <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            pm_addr  <= addr_in;
            pm_re    <= 1'b1;
            busy     <= 1'b1;
            dst_addr <= op_dst;
            state    <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          pm_re <= 1'b0;
          state <= ST_CAPT;
        end
        ST_CAPT: begin
          dst_data <= pm_rdata[BYTE_W-1:0];
          dst_we   <= 1'b1;
          busy     <= 1'b0;
          state    <= ST_IDLE;
        end
        default: begin
          pm_re <= 1'b0;
          busy  <= 1'b0;
          state <= ST_IDLE;
        end
      endcase
    end
  end

  // R5
  re_then_wait_chk: assert property (@(posedge clk) disable iff (rst)
    pm_re |=> busy && !pm_re);

  // R5
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    pm_re |=> $stable(pm_addr));

  // R6
  result_slot_chk: assert property (@(posedge clk) disable iff (rst)
    pm_re |-> ##2 (dst_we && !busy));

  // R6
  we_single_chk: assert property (@(posedge clk) disable iff (rst)
    dst_we |=> !dst_we);

endmodule

// File: rtl/tblrd_unit.sv
module tblrd_unit
  import tblrd_pkg::*;
#(
  parameter int PC_W   = 11,
  parameter int PTR_W  = 8,
  parameter int WORD_W = 16,
  parameter int DST_AW = 7
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    op_valid,
  input  logic                    op_last,
  input  logic [DST_AW-1:0]       op_dst,
  input  logic [PC_W-PTR_W-1:0]   pc_page,
  input  logic                    wr_en,
  input  logic                    wr_sel,
  input  logic [PTR_W-1:0]        wr_data,
  output logic                    pm_re,
  output logic [PC_W-1:0]         pm_addr,
  input  logic [WORD_W-1:0]       pm_rdata,
  output logic                    busy,
  output logic                    dst_we,
  output logic [DST_AW-1:0]       dst_addr,
  output logic [WORD_W/2-1:0]     dst_data,
  output logic [WORD_W/2-1:0]     hb_q,
  output logic [PTR_W-1:0]        ptr_q
);

  localparam int PAGE_W = PC_W - PTR_W;
  localparam int BYTE_W = WORD_W / 2;

  logic              ptr_we;
  logic [PC_W-1:0]   addr_next;
  logic              cap_en;
  logic [BYTE_W-1:0] hi_byte;

  assign ptr_we = wr_en && (wr_sel == SEL_PTR);

  tblrd_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk   (clk),
    .rst   (rst),
    .we    (ptr_we),
    .wdata (wr_data),
    .ptr   (ptr_q)
  );

  tblrd_addr #(.PC_W(PC_W), .PTR_W(PTR_W)) u_addr (
    .last_page (op_last),
    .pc_page   (pc_page),
    .ptr       (ptr_q),
    .addr      (addr_next)
  );

  tblrd_ctrl #(.PC_W(PC_W), .WORD_W(WORD_W), .DST_AW(DST_AW)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .op_valid (op_valid),
    .op_dst   (op_dst),
    .addr_in  (addr_next),
    .pm_rdata (pm_rdata),
    .pm_re    (pm_re),
    .pm_addr  (pm_addr),
    .busy     (busy),
    .cap_en   (cap_en),
    .hi_byte  (hi_byte),
    .dst_we   (dst_we),
    .dst_addr (dst_addr),
    .dst_data (dst_data)
  );

  tblrd_hold #(.BYTE_W(BYTE_W)) u_hold (
    .clk  (clk),
    .rst  (rst),
    .load (cap_en),
    .din  (hi_byte),
    .q    (hb_q)
  );

  // R2
  low_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !busy) |=> pm_addr[PTR_W-1:0] == $past(ptr_q));

  // R3
  cur_page_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !busy && !op_last) |=> pm_addr[PC_W-1:PTR_W] == $past(pc_page));

  // R4
  last_page_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !busy && op_last) |=> pm_addr[PC_W-1:PTR_W] == {PAGE_W{1'b1}});

  // R10
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && busy) |=> !pm_re);

  // R8
  hb_write_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == SEL_HB && !cap_en) |=> $stable(hb_q) && $stable(ptr_q));

endmodule

// File: tb/tb_tblrd_unit.sv
module tb_tblrd_unit;

  typedef struct packed {
    logic [10:0] addr;
    logic [7:0]  lo;
    logic [7:0]  hi;
    logic [6:0]  dst;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst;
  logic        op_valid, op_last;
  logic [6:0]  op_dst;
  logic [2:0]  pc_page;
  logic        wr_en, wr_sel;
  logic [7:0]  wr_data;
  logic        pm_re;
  logic [10:0] pm_addr;
  logic [15:0] pm_rdata;
  logic        busy, dst_we;
  logic [6:0]  dst_addr;
  logic [7:0]  dst_data, hb_q, ptr_q;

  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;
  exp_t q[$];
  logic [7:0] tb_ptr;
  logic [7:0] last_hi;

  always #5 clk = ~clk;

  tblrd_unit dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_last(op_last),
    .op_dst(op_dst), .pc_page(pc_page), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .pm_re(pm_re), .pm_addr(pm_addr), .pm_rdata(pm_rdata),
    .busy(busy), .dst_we(dst_we), .dst_addr(dst_addr), .dst_data(dst_data),
    .hb_q(hb_q), .ptr_q(ptr_q)
  );

  function automatic logic [15:0] mem_word(input logic [10:0] a);
    logic [7:0] lo, hi;
    lo = a[7:0] ^ 8'h5A;
    hi = {a[10:8], a[4:0]} ^ 8'hC3;
    return {hi, lo};
  endfunction

  // synchronous program memory model
  always @(posedge clk) if (pm_re) pm_rdata <= mem_word(pm_addr);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: scoreboard pop and compare
  always @(posedge clk) begin
    #1;
    if (!rst && !done) begin
      if (pm_re) begin
        if (q.size() == 0) chk(1'b0, "R10", "unexpected fetch", {21'b0, pm_addr}, 0);
        else chk(pm_addr == q[0].addr, "R2/R3/R4", "pm_addr", {21'b0, pm_addr}, {21'b0, q[0].addr});
      end
      if (dst_we) begin
        if (q.size() == 0) chk(1'b0, "R10", "unexpected dst write", {25'b0, dst_addr}, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk(dst_data == e.lo, "R6", "dst_data", {24'b0, dst_data}, {24'b0, e.lo});
          chk(dst_addr == e.dst, "R6", "dst_addr", {25'b0, dst_addr}, {25'b0, e.dst});
          chk(hb_q == e.hi, "R7", "hb_q", {24'b0, hb_q}, {24'b0, e.hi});
          last_hi = e.hi;
        end
      end
    end
  end

  // mode: 0 plain, 1 pointer write with strobe, 2 change inputs in flight, 3 hold strobe
  task automatic do_op(input logic last, input logic [2:0] pg, input logic [6:0] dst,
                       input int mode, input logic [7:0] nptr);
    exp_t e;
    logic [10:0] a;
    @(negedge clk);
    a = {last ? 3'b111 : pg, tb_ptr};
    e.addr = a;
    e.lo = mem_word(a)[7:0];
    e.hi = mem_word(a)[15:8];
    e.dst = dst;
    q.push_back(e);
    op_valid = 1'b1; op_last = last; pc_page = pg; op_dst = dst;
    if (mode == 1) begin
      wr_en = 1'b1; wr_sel = 1'b0; wr_data = nptr; tb_ptr = nptr;
    end
    @(negedge clk);
    wr_en = 1'b0;
    if (mode != 3) op_valid = 1'b0;
    else begin op_last = ~last; op_dst = ~dst; end
    chk(busy && pm_re, "R5", "cycle1 busy/pm_re", {30'b0, busy, pm_re}, 32'h3);
    if (mode == 2) begin
      pc_page = ~pg; op_last = ~last; op_dst = ~dst;
      wr_en = 1'b1; wr_sel = 1'b0; wr_data = nptr; tb_ptr = nptr;
    end
    @(negedge clk);
    wr_en = 1'b0;
    chk(busy && !pm_re, "R5", "cycle2 busy/pm_re", {30'b0, busy, pm_re}, 32'h2);
    if (mode == 2) chk(ptr_q == nptr, "R11", "pointer updated mid-flight", {24'b0, ptr_q}, {24'b0, nptr});
    @(negedge clk);
    op_valid = 1'b0;
    chk(!busy && dst_we, "R5", "cycle3 busy/dst_we", {30'b0, busy, dst_we}, 32'h1);
  endtask

  task automatic write_reg(input logic sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    if (sel == 1'b0) tb_ptr = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; op_valid = 1'b0; op_last = 1'b0; op_dst = '0; pc_page = '0;
    wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0; tb_ptr = 8'h00; last_hi = 8'h00;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ptr_q == 8'h00, "R1", "ptr_q", {24'b0, ptr_q}, 0);
    chk(hb_q == 8'h00, "R1", "hb_q", {24'b0, hb_q}, 0);
    chk(!busy && !pm_re && !dst_we, "R1", "busy/pm_re/dst_we", {29'b0, busy, pm_re, dst_we}, 0);
    rst = 1'b0;

    // R9 pointer write
    write_reg(1'b0, 8'h3C);
    chk(ptr_q == 8'h3C, "R9", "ptr write", {24'b0, ptr_q}, 32'h3C);

    // R2 R3 current page, several pages
    do_op(1'b0, 3'd2, 7'h11, 0, 8'h00);
    do_op(1'b0, 3'd5, 7'h12, 0, 8'h00);
    // R4 last page
    do_op(1'b1, 3'd0, 7'h13, 0, 8'h00);
    write_reg(1'b0, 8'hFF);
    do_op(1'b1, 3'd3, 7'h7F, 0, 8'h00);
    do_op(1'b0, 3'd0, 7'h00, 0, 8'h00);

    // R8 write to high-byte register ignored
    write_reg(1'b1, ~last_hi);
    chk(hb_q == last_hi, "R8", "hb after write", {24'b0, hb_q}, {24'b0, last_hi});
    chk(ptr_q == 8'hFF, "R8", "ptr after hb write", {24'b0, ptr_q}, 32'hFF);

    // R9 pointer write in same cycle as strobe: old pointer used
    do_op(1'b0, 3'd6, 7'h21, 1, 8'h81);
    chk(ptr_q == 8'h81, "R9", "ptr after coincident write", {24'b0, ptr_q}, 32'h81);

    // R11 inputs change while in flight
    do_op(1'b0, 3'd1, 7'h22, 2, 8'h47);
    do_op(1'b1, 3'd4, 7'h23, 2, 8'h09);

    // R10 strobe held during busy
    do_op(1'b0, 3'd7, 7'h30, 3, 8'h00);
    do_op(1'b1, 3'd2, 7'h31, 3, 8'h00);
    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R10", "pending results", q.size(), 0);
    chk(!busy, "R10", "busy after held strobe", {31'b0, busy}, 0);

    // R7 holding register keeps value
    repeat (3) @(negedge clk);
    chk(hb_q == last_hi, "R7", "hb retained", {24'b0, hb_q}, {24'b0, last_hi});

    // R1 mid-run reset
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(hb_q == 8'h00 && ptr_q == 8'h00, "R1", "regs after reset", {16'b0, hb_q, ptr_q}, 0);
    tb_ptr = 8'h00;
    do_op(1'b1, 3'd0, 7'h05, 0, 8'h00);
    repeat (2) @(negedge clk);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule